// File: doc/BRIEF.md
# Smart Card Character Transceiver

This block moves single characters between a host and a contact smart card over one shared, open-drain I/O line. It works in half duplex. A built-in divider derives every bit time from the system clock. The same divider can also drive a card clock pin at 372 card-clock periods per bit. Host-side convention controls set three things independently: the bit order, the inversion of the data bits and the parity sense. A transmitted character is a low start bit, eight data bits and a parity bit, followed by two released guard bits.

On receive, the block waits for the line to fall, samples each bit at the middle of its bit time and undoes the order and inversion. It then presents the byte together with a parity-error flag and a one-cycle done strobe. The inversion control never touches the parity bit. For the inverse convention the host therefore also selects odd parity, so that the line carries correct even parity.

Top module: `sc_char_io`

## Requirements
- R1: While `clk_out_en` is 1, `card_clk` toggles every 4^`presel` × (`divisor`+1) system clocks, so its period is 2 × 4^`presel` × (`divisor`+1) system clocks.
- R2: While `clk_out_en` is 0, `card_clk` stays low.
- R3: A transmitted frame has twelve bit times of 744 × 4^`presel` × (`divisor`+1) system clocks each, which is 372 card-clock periods per bit. The bit times are, in order: a low start bit, eight data bits, the parity bit, and two guard bits with the line released (high).
- R4: With `msb_first`=0 and `invert_data`=0, data bit k of the line is byte bit k, and a 1 is sent high. Sent this way with even parity, 0x3B carries a parity bit of 1.
- R5: With `msb_first`=1 and `invert_data`=1, data bit k of the line is the complement of byte bit 7−k. Sent this way with `odd_parity`=1, 0x3F carries a high parity bit.
- R6: The parity line level equals the XOR of the eight unmodified byte bits XOR `odd_parity`, whatever the value of `invert_data`.
- R7: `io_oe` is 1 only inside a frame (`tx_busy`=1) and only while the line level is low. `io_out` gives the line level and is 0 whenever `io_oe` is 1.
- R8: `tx_send` is accepted only while `tx_busy` is 0. `tx_busy` is 1 in the cycle after an accepted strobe, and a strobe while busy starts no frame.
- R9: After a frame on `io_in`, `rx_data` holds the byte with the order and inversion undone, and `rx_done` pulses for one cycle. `rx_data` changes only with `rx_done`.
- R10: `rx_parity_err` is set with `rx_done` when the received parity level differs from XOR(decoded byte) XOR `odd_parity`, is cleared otherwise, and changes only with `rx_done`.
- R11: A low pulse on `io_in` that has ended before the middle of a start bit is dropped, and the receiver is ready for the next falling edge.
- R12: During reset `io_oe`, `tx_busy`, `rx_done` and `card_clk` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| divisor | input | 8 | Bit-rate divisor N |
| presel | input | 2 | Prescaler select n (factor 4^n) |
| msb_first | input | 1 | 1: data bits go out most significant first |
| invert_data | input | 1 | 1: data bits are complemented on the line |
| odd_parity | input | 1 | 1: odd parity sense, 0: even |
| clk_out_en | input | 1 | Enables the card clock output |
| tx_data | input | 8 | Byte to transmit |
| tx_send | input | 1 | Transmit strobe |
| tx_busy | output | 1 | Frame in progress |
| rx_data | output | 8 | Last received byte |
| rx_parity_err | output | 1 | Parity error of the last received byte |
| rx_done | output | 1 | One-cycle strobe for a received byte |
| io_out | output | 1 | Line level being driven |
| io_oe | output | 1 | Pulls the line low when 1 |
| io_in | input | 1 | Line level seen from the card |
| card_clk | output | 1 | Card clock |

## Verification
The bench sweeps the card clock across several prescaler and divisor pairs. A wrong prescaler exponent or an off-by-one in the divider shows up as a wrong period. It sends characters under the direct convention, the inverse convention and both mixed conventions, and samples every bit at mid-bit. A design that inverted the parity bit with the data, or that sent the bits in the wrong order, would fail here on 0x3B or 0x3F. Bench-driven frames test the receiver with a bad parity bit and with a short glitch before a real frame. A receiver without the start-bit check would misframe that real frame. A strobe sent in the middle of a frame must not start a second frame.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
  localparam int DATA_W = 8;

  function automatic logic [DATA_W-1:0] sc_rev(input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = b[DATA_W-1-i];
    return r;
  endfunction

  // byte -> line levels, element 0 goes out first
  function automatic logic [DATA_W-1:0] sc_encode(input logic [DATA_W-1:0] b,
                                                  input logic msb, input logic inv);
    logic [DATA_W-1:0] o;
    o = msb ? sc_rev(b) : b;
    return o ^ {DATA_W{inv}};
  endfunction

  // line levels in arrival order -> byte
  function automatic logic [DATA_W-1:0] sc_decode(input logic [DATA_W-1:0] v,
                                                  input logic msb, input logic inv);
    logic [DATA_W-1:0] t;
    t = v ^ {DATA_W{inv}};
    return msb ? sc_rev(t) : t;
  endfunction

  // parity level, never inverted
  function automatic logic sc_parity(input logic [DATA_W-1:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction
endpackage

// File: rtl/sc_baud.sv
`timescale 1ns/1ps
module sc_baud #(
  parameter int DIV_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic [SEL_W-1:0] presel,
  output logic             half_tick,
  output logic             clk_phase
);
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pre_cnt, pre_limit;
  logic [DIV_W-1:0] div_cnt;
  logic             pre_wrap;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) pre_limit[i] = (i < 2 * int'(presel));
  end

  assign pre_wrap  = (pre_cnt >= pre_limit);
  assign half_tick = pre_wrap && (div_cnt >= divisor);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      div_cnt   <= '0;
      clk_phase <= 1'b0;
    end else begin
      if (pre_wrap) begin
        pre_cnt <= '0;
        div_cnt <= (div_cnt >= divisor) ? '0 : div_cnt + 1'b1;
      end else begin
        pre_cnt <= pre_cnt + 1'b1;
      end
      if (half_tick) clk_phase <= ~clk_phase;
    end
  end
endmodule

// File: rtl/sc_tx.sv
`timescale 1ns/1ps
module sc_tx
  import sc_pkg::*;
#(
  parameter int HALF_PER_BIT = 744,
  parameter int GUARD_BITS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              msb_first,
  input  logic              invert_data,
  input  logic              odd_parity,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_send,
  output logic              tx_busy,
  output logic              line_level
);
  localparam int FRAME = DATA_W + 2 + GUARD_BITS;
  localparam int CNT_W = $clog2(HALF_PER_BIT);
  localparam int IDX_W = $clog2(FRAME);

  logic [FRAME-1:0] shreg;
  logic [CNT_W-1:0] etu_cnt;
  logic [IDX_W-1:0] bit_idx;
  logic             accept, bit_end;

  assign accept     = tx_send && !tx_busy;
  assign bit_end    = tx_busy && half_tick && (etu_cnt == CNT_W'(HALF_PER_BIT - 1));
  assign line_level = tx_busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg   <= '1;
      etu_cnt <= '0;
      bit_idx <= '0;
      tx_busy <= 1'b0;
    end else if (accept) begin
      shreg   <= {{GUARD_BITS{1'b1}}, sc_parity(tx_data, odd_parity),
                  sc_encode(tx_data, msb_first, invert_data), 1'b0};
      etu_cnt <= '0;
      bit_idx <= '0;
      tx_busy <= 1'b1;
    end else if (bit_end) begin
      etu_cnt <= '0;
      shreg   <= {1'b1, shreg[FRAME-1:1]};
      if (bit_idx == IDX_W'(FRAME - 1)) tx_busy <= 1'b0;
      else bit_idx <= bit_idx + 1'b1;
    end else if (tx_busy && half_tick) begin
      etu_cnt <= etu_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sc_rx.sv
`timescale 1ns/1ps
module sc_rx
  import sc_pkg::*;
#(
  parameter int HALF_PER_BIT = 744,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_tick,
  input  logic              msb_first,
  input  logic              invert_data,
  input  logic              odd_parity,
  input  logic              io_in,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_parity_err,
  output logic              rx_done
);
  localparam int CNT_W = $clog2(HALF_PER_BIT);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam int MID   = HALF_PER_BIT / 2 - 1;

  logic [SYNC_STAGES-1:0] sync;
  logic                   rx_s, rx_prev, active, fall, sample_hit;
  logic [CNT_W-1:0]       etu_cnt;
  logic [IDX_W-1:0]       bit_idx;
  logic [DATA_W-1:0]      vec, decoded;

  assign rx_s       = sync[SYNC_STAGES-1];
  assign fall       = rx_prev && !rx_s;
  assign sample_hit = active && half_tick && (etu_cnt == CNT_W'(MID));
  assign decoded    = sc_decode(vec, msb_first, invert_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync    <= '1;
      rx_prev <= 1'b1;
    end else begin
      sync    <= {sync[SYNC_STAGES-2:0], io_in};
      rx_prev <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active        <= 1'b0;
      etu_cnt       <= '0;
      bit_idx       <= '0;
      vec           <= '0;
      rx_data       <= '0;
      rx_parity_err <= 1'b0;
      rx_done       <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (!active) begin
        if (fall) begin
          active  <= 1'b1;
          etu_cnt <= '0;
          bit_idx <= '0;
        end
      end else begin
        if (half_tick)
          etu_cnt <= (etu_cnt == CNT_W'(HALF_PER_BIT - 1)) ? '0 : etu_cnt + 1'b1;
        if (sample_hit) begin
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == '0) begin
            if (rx_s) active <= 1'b0;          // start bit gone: glitch
          end else if (bit_idx == IDX_W'(DATA_W + 1)) begin
            rx_data       <= decoded;
            rx_parity_err <= rx_s != sc_parity(decoded, odd_parity);
            rx_done       <= 1'b1;
            active        <= 1'b0;
          end else begin
            vec <= {rx_s, vec[DATA_W-1:1]};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sc_char_io.sv
`timescale 1ns/1ps
module sc_char_io
  import sc_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SEL_W       = 2,
  parameter int CLK_PER_ETU = 372,
  parameter int GUARD_BITS  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [SEL_W-1:0]  presel,
  input  logic              msb_first,
  input  logic              invert_data,
  input  logic              odd_parity,
  input  logic              clk_out_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_send,
  output logic              tx_busy,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_parity_err,
  output logic              rx_done,
  output logic              io_out,
  output logic              io_oe,
  input  logic              io_in,
  output logic              card_clk
);
  localparam int HALF_PER_BIT = 2 * CLK_PER_ETU;

  logic half_tick, clk_phase, line_level;

  sc_baud #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .presel(presel),
    .half_tick(half_tick), .clk_phase(clk_phase)
  );

  sc_tx #(.HALF_PER_BIT(HALF_PER_BIT), .GUARD_BITS(GUARD_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .msb_first(msb_first), .invert_data(invert_data), .odd_parity(odd_parity),
    .tx_data(tx_data), .tx_send(tx_send), .tx_busy(tx_busy), .line_level(line_level)
  );

  sc_rx #(.HALF_PER_BIT(HALF_PER_BIT), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .msb_first(msb_first), .invert_data(invert_data), .odd_parity(odd_parity),
    .io_in(io_in), .rx_data(rx_data), .rx_parity_err(rx_parity_err), .rx_done(rx_done)
  );

  assign io_out   = line_level;
  assign io_oe    = !line_level;
  assign card_clk = clk_phase && clk_out_en;
endmodule

// File: rtl/sc_char_io_chk.sv
`timescale 1ns/1ps
module sc_char_io_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       half_tick,
  input logic       clk_out_en,
  input logic       card_clk,
  input logic       tx_send,
  input logic       tx_busy,
  input logic       io_oe,
  input logic       rx_done,
  input logic [7:0] rx_data,
  input logic       rx_parity_err
);
  a_r1_clk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out_en && !half_tick) |=> (!clk_out_en || $stable(card_clk)));
  a_r1_clk_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_out_en && half_tick) |=> (!clk_out_en || !$stable(card_clk)));
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> io_oe);
  a_r7_oe_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> tx_busy);
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_send && !tx_busy) |=> tx_busy);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_data));
  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> $stable(rx_parity_err));
endmodule

bind sc_char_io sc_char_io_chk u_chk (
  .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .clk_out_en(clk_out_en),
  .card_clk(card_clk), .tx_send(tx_send), .tx_busy(tx_busy), .io_oe(io_oe),
  .rx_done(rx_done), .rx_data(rx_data), .rx_parity_err(rx_parity_err)
);

// File: tb/test_sc_char_io.sv
`timescale 1ns/1ps
module test_sc_char_io;
  localparam int BIT = 744;  // presel 0, divisor 0

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic [1:0] presel = 2'd0;
  logic       msb_first = 0, invert_data = 0, odd_parity = 0, clk_out_en = 0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_send = 0;
  logic       tx_busy, rx_parity_err, rx_done, io_out, io_oe, io_in, card_clk;
  logic [7:0] rx_data;
  logic       tb_drive = 0, tb_line = 1;

  int n_tests = 0, n_fail = 0;
  int done_cnt = 0, cyc = 0, busy_rise = 0, busy_len = 0;
  logic [7:0] last_rx = 0;
  logic last_err = 0, busy_q = 0;

  always #4 clk = ~clk;
  assign io_in = tb_drive ? tb_line : ~io_oe;

  sc_char_io i_sc_char_io (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .presel(presel),
    .msb_first(msb_first), .invert_data(invert_data), .odd_parity(odd_parity),
    .clk_out_en(clk_out_en), .tx_data(tx_data), .tx_send(tx_send), .tx_busy(tx_busy),
    .rx_data(rx_data), .rx_parity_err(rx_parity_err), .rx_done(rx_done),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .card_clk(card_clk)
  );

  always @(negedge clk) begin
    cyc++;
    if (rx_done) begin done_cnt++; last_rx = rx_data; last_err = rx_parity_err; end
    if (tx_busy && !busy_q) busy_rise = cyc;
    if (!tx_busy && busy_q) busy_len = cyc - busy_rise;
    busy_q = tx_busy;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench's own frame model: element 0 start, 1..8 data, 9 parity
  function automatic logic [9:0] model_frame(input logic [7:0] b, input bit msb,
                                             input bit inv, input bit odd);
    logic [9:0] f;
    int ones = 0;
    f[0] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      f[k+1] = b[msb ? 7 - k : k] ^ inv;
      if (b[k]) ones++;
    end
    f[9] = ((ones % 2) == 1) ^ odd;
    return f;
  endfunction

  task automatic send_check(input logic [7:0] b, input bit msb, input bit inv,
                            input bit odd, input string req);
    logic [11:0] lv;
    logic [9:0] exp_f;
    int g = 0, d0;
    exp_f = model_frame(b, msb, inv, odd);
    @(negedge clk);
    msb_first = msb; invert_data = inv; odd_parity = odd; tx_data = b; tx_send = 1;
    @(negedge clk);
    tx_send = 0;
    d0 = done_cnt;
    while (!io_oe && g < 2000) begin @(negedge clk); g++; end
    wait_cyc(BIT / 2);
    for (int k = 0; k < 12; k++) begin
      lv[k] = io_oe ? 1'b0 : 1'b1;
      if (io_oe) check(io_out == 1'b0, "R7 io_out low while driving", io_out, 0);
      if (k < 11) wait_cyc(BIT);
    end
    check(lv[0] == 1'b0, {req, " R3 start bit"}, lv[0], 0);
    check(lv[8:1] == exp_f[8:1], {req, " data bits"}, lv[8:1], exp_f[8:1]);
    check(lv[9] == exp_f[9], {req, " R6 parity level"}, lv[9], exp_f[9]);
    check(lv[11:10] == 2'b11, {req, " R3 guard"}, lv[11:10], 3);
    g = 0;
    while (tx_busy && g < 2000) begin @(negedge clk); g++; end
    wait_cyc(2);
    check(busy_len >= 12 * BIT - 2 && busy_len <= 12 * BIT + 2, "R3 frame length",
          busy_len, 12 * BIT);
    check(done_cnt == d0 + 1, {req, " R9 one done"}, done_cnt - d0, 1);
    check(last_rx == b && last_err == 1'b0, {req, " R9 loopback byte"},
          {last_err, last_rx}, b);
  endtask

  task automatic drive_frame(input logic [9:0] f);
    tb_drive = 1;
    for (int k = 0; k < 10; k++) begin tb_line = f[k]; wait_cyc(BIT); end
    tb_line = 1;
    wait_cyc(2 * BIT);
    tb_drive = 0;
  endtask

  task automatic clk_period(input int n, input int nd);
    int c = 0, g = 0, expv;
    @(negedge clk);
    presel = 2'(n); divisor = 8'(nd); clk_out_en = 1;
    wait_cyc(600);
    while (card_clk && g < 2000) begin @(negedge clk); g++; end
    while (!card_clk && g < 2000) begin @(negedge clk); g++; end
    while (card_clk && c < 2000) begin @(negedge clk); c++; end
    while (!card_clk && c < 2000) begin @(negedge clk); c++; end
    expv = 2 * (4 ** n) * (nd + 1);
    check(c == expv, $sformatf("R1 card clock period n=%0d N=%0d", n, nd), c, expv);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int d0;
    wait_cyc(5);
    // R12 reset state
    check({io_oe, tx_busy, rx_done, card_clk} == 4'b0, "R12 reset outputs",
          {io_oe, tx_busy, rx_done, card_clk}, 0);
    rst_n = 1;
    // R2 gated clock
    begin
      bit seen = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (card_clk) seen = 1; end
      check(!seen, "R2 card clock held low", seen, 0);
    end
    clk_period(0, 0);
    clk_period(0, 5);
    clk_period(1, 2);
    clk_period(2, 0);
    clk_period(3, 1);
    @(negedge clk);
    presel = 0; divisor = 0;
    wait_cyc(600);

    send_check(8'h3B, 0, 0, 0, "R4 direct 0x3B");
    check(model_frame(8'h3B, 0, 0, 0)[9] == 1'b1, "R4 0x3B parity is 1", 0, 1);
    send_check(8'h3F, 1, 1, 1, "R5 inverse 0x3F");
    check(model_frame(8'h3F, 1, 1, 1)[9] == 1'b1, "R5 0x3F parity high", 0, 1);
    send_check(8'hA5, 1, 0, 0, "R6 msb only");
    send_check(8'h5A, 0, 1, 0, "R6 invert only");
    send_check(8'h00, 0, 1, 1, "R6 zero inverted odd");
    send_check(8'hFF, 1, 1, 0, "R5 all ones inverse");

    // R8 strobe while busy ignored
    d0 = done_cnt;
    @(negedge clk); msb_first = 0; invert_data = 0; odd_parity = 0;
    tx_data = 8'hC3; tx_send = 1;
    @(negedge clk); tx_send = 0;
    wait_cyc(3 * BIT);
    tx_data = 8'h11; tx_send = 1;
    @(negedge clk); tx_send = 0;
    while (tx_busy) @(negedge clk);
    begin
      bit restarted = 0;
      for (int i = 0; i < 2 * BIT; i++) begin
        @(negedge clk); if (io_oe || tx_busy) restarted = 1;
      end
      check(!restarted, "R8 no second frame", restarted, 0);
    end
    check(done_cnt == d0 + 1 && last_rx == 8'hC3, "R8 first byte kept", last_rx, 8'hC3);

    // R10 bad parity from the card
    d0 = done_cnt;
    begin
      logic [9:0] f;
      f = model_frame(8'hA5, 0, 0, 0);
      f[9] = ~f[9];
      drive_frame(f);
    end
    check(done_cnt == d0 + 1, "R10 done on bad parity", done_cnt - d0, 1);
    check(last_err == 1'b1 && last_rx == 8'hA5, "R10 parity error flagged",
          {last_err, last_rx}, 9'h1A5);

    // R9 card frame, inverse convention with bit order reversed
    d0 = done_cnt;
    @(negedge clk); msb_first = 1; invert_data = 1; odd_parity = 1;
    drive_frame(model_frame(8'h3F, 1, 1, 1));
    check(done_cnt == d0 + 1 && last_rx == 8'h3F && !last_err, "R9 inverse receive",
          {last_err, last_rx}, 8'h3F);

    // R11 short glitch then a real frame
    d0 = done_cnt;
    @(negedge clk); msb_first = 0; invert_data = 0; odd_parity = 0;
    tb_drive = 1; tb_line = 0; wait_cyc(100); tb_line = 1; wait_cyc(1500);
    drive_frame(model_frame(8'h5A, 0, 0, 0));
    check(done_cnt == d0 + 1, "R11 glitch dropped, one done", done_cnt - d0, 1);
    check(last_rx == 8'h5A && !last_err, "R11 frame after glitch",
          {last_err, last_rx}, 8'h5A);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule